// File: doc/BRIEF.md
# Dual-Channel DAC Command and Register Core

This block is the digital control core of a two-channel, serially programmed digital-to-analog converter. A host sends 24-bit command frames over a 3-wire serial link (chip select, clock, data). The block brings the link into its own clock domain, counts and captures the bits, and carries out a frame when chip select is released. Each channel keeps a double-buffered pair of codes: a staging register that holds a pending value, and an output register whose value drives the converter.

Commands can stage a code, stage and apply it in one step, move staged values to the outputs, power channels down or up, pick the reference source, and zero or fully reset the block. Powering a channel down leaves its codes in place, so it comes back at the same value. A separate asynchronous active-low clear input zeroes every code at once, with no clock needed. It also cancels any frame that is being received. The outputs are the applied code of each channel, a power-down flag per channel and a reference-select field. The analog parts are outside this block.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After rst_ni is released, every channel code reads zero, pwr_dn_o is all zero (all channels powered up) and ref_sel_o is 2'b00 (external reference).
- R2: A frame with command 4'h0 (stage) writes only the staging register of each selected channel. code_o does not change.
- R3: Command 4'h1 (apply) copies the staging register of each selected channel to its output register. Channels that are not selected keep their output.
- R4: Command 4'h2 (stage-and-apply) writes the code to both the staging and the output register of each selected channel. code_o shows the new value once the frame is carried out.
- R5: The select field (frame bits 19:16) picks channel 0 with 4'h0, channel 1 with 4'h1 and all channels with 4'hF. A channel command with any other select value changes nothing.
- R6: The code is left-justified in the 16-bit data field (frame bits 15:0): the code is data[15:16-RES_W], and the lower data bits are ignored.
- R7: Command 4'h4 sets the power-down flag of each selected channel to data bit 0 (1 = down, 0 = up). It leaves all codes unchanged. Commands 4'h0, 4'h1 and 4'h2 still update the registers of a powered-down channel.
- R8: Command 4'h7 loads ref_sel_o from data[1:0], with 00 = external, 01 = 2.048 V, 10 = 2.500 V and 11 = 4.096 V. The select field is ignored.
- R9: Command 4'h5 (software clear) zeroes every staging and output register. Power flags and the reference selection are kept.
- R10: Command 4'h6 (software reset) zeroes every staging and output register, powers all channels up and returns ref_sel_o to external.
- R11: While clr_ni is low, every staging and output register is zero, with no clock edge needed. Power flags and the reference selection are not affected.
- R12: A frame during which clr_ni was asserted is dropped, even if 24 bits in total arrive. The first full frame after clr_ni returns high is carried out normally.
- R13: A frame is carried out on the rising edge of cs_n_i only if exactly 24 bits were captured on falling edges of sclk_i, MSB first. Shorter frames, longer frames and frames with an undefined command code change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; the serial pins are sampled with it |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| clr_ni | input | 1 | Asynchronous active-low code clear and frame abort |
| sclk_i | input | 1 | Serial clock; data is captured on its falling edge |
| cs_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| code_o | output | NUM_CH*RES_W | Applied code per channel; channel n is at bits [n*RES_W +: RES_W] |
| pwr_dn_o | output | NUM_CH | Per-channel power-down flag |
| ref_sel_o | output | 2 | Reference selection |

## Verification
The bench goes after the corner cases where the staging and output registers drift apart. It checks that a stage-only write has no effect on the output until an apply frame is sent. A design that merged the two registers would show the new value at once. Frames that are 23 or 25 bits long, a select value of 4'h3, and an undefined command are each followed by apply frames, so that any hidden change to a staging register shows up at code_o. Commands sent to a powered-down channel must still take effect. A clear pulse in the middle of a frame, followed by exactly enough bits to make 24 in total, must not execute. A design that only counted bits would run the leftover frame. Software clear and software reset are told apart by whether the power flags and the reference selection survive.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int FRAME_W = 24;
  localparam int CMD_W   = 4;
  localparam int SEL_W   = 4;
  localparam int DATA_W  = 16;

  localparam logic [SEL_W-1:0] SEL_ALL = 4'hF;

  localparam logic [CMD_W-1:0] CMD_STAGE    = 4'h0;
  localparam logic [CMD_W-1:0] CMD_APPLY    = 4'h1;
  localparam logic [CMD_W-1:0] CMD_STG_APP  = 4'h2;
  localparam logic [CMD_W-1:0] CMD_POWER    = 4'h4;
  localparam logic [CMD_W-1:0] CMD_SW_CLEAR = 4'h5;
  localparam logic [CMD_W-1:0] CMD_SW_RESET = 4'h6;
  localparam logic [CMD_W-1:0] CMD_REF      = 4'h7;

  typedef enum logic [1:0] {
    REF_EXT   = 2'b00,
    REF_2V048 = 2'b01,
    REF_2V500 = 2'b10,
    REF_4V096 = 2'b11
  } ref_e;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dacc_sync.sv
module dacc_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dacc_spi_rx.sv
module dacc_spi_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_rst_ni,
  input  logic               sclk_i,
  input  logic               cs_n_i,
  input  logic               sdi_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int               CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

  logic               sclk_q, cs_n_q;
  logic               sclk_fall, cs_rise;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               abort_q;
  logic               vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_n_q <= cs_n_i;
    end
  end

  assign sclk_fall = sclk_q & ~sclk_i;
  assign cs_rise   = ~cs_n_q & cs_n_i;

  // abort_q comes up set after a clear and drops only once the frame select is idle
  always_ff @(posedge clk_i or negedge clr_rst_ni) begin
    if (!clr_rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      abort_q <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= cs_rise && !abort_q && (cnt_q == CNT_OK);
      if (cs_n_i) begin
        cnt_q   <= '0;
        abort_q <= 1'b0;
      end else if (sclk_fall) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = shift_q;

  a_r12_abort_blocks: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    abort_q |=> !frame_vld_o);
  a_r13_single_pulse: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    frame_vld_o |=> !frame_vld_o);
  a_r13_idle_on_exec: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    frame_vld_o |-> cs_n_q);
endmodule

// File: rtl/dacc_decode.sv
module dacc_decode
  import dacc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int RES_W  = 12
) (
  input  logic              frame_vld_i,
  input  frame_t            frame_i,
  output logic [NUM_CH-1:0] stage_o,
  output logic [NUM_CH-1:0] stg_app_o,
  output logic [NUM_CH-1:0] apply_o,
  output logic [NUM_CH-1:0] pwr_en_o,
  output logic              pwr_val_o,
  output logic              ref_en_o,
  output ref_e              ref_val_o,
  output logic              zero_o,
  output logic              sw_rst_o,
  output logic [RES_W-1:0]  code_o
);
  logic [NUM_CH-1:0] hit;
  logic              unused_low;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
    assign hit[ch] = (frame_i.sel == SEL_W'(ch)) || (frame_i.sel == SEL_ALL);
  end

  always_comb begin
    stage_o   = '0;
    stg_app_o = '0;
    apply_o   = '0;
    pwr_en_o  = '0;
    ref_en_o  = 1'b0;
    zero_o    = 1'b0;
    sw_rst_o  = 1'b0;
    if (frame_vld_i) begin
      case (frame_i.cmd)
        CMD_STAGE:    stage_o   = hit;
        CMD_APPLY:    apply_o   = hit;
        CMD_STG_APP:  stg_app_o = hit;
        CMD_POWER:    pwr_en_o  = hit;
        CMD_SW_CLEAR: zero_o    = 1'b1;
        CMD_SW_RESET: begin
          zero_o   = 1'b1;
          sw_rst_o = 1'b1;
        end
        CMD_REF:      ref_en_o  = 1'b1;
        default: ;
      endcase
    end
  end

  assign code_o     = frame_i.data[DATA_W-1 -: RES_W];
  assign pwr_val_o  = frame_i.data[0];
  assign ref_val_o  = ref_e'(frame_i.data[1:0]);
  assign unused_low = ^frame_i.data;
endmodule

// File: rtl/dacc_chan.sv
module dacc_chan #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             clr_rst_ni,
  input  logic             stage_i,
  input  logic             stg_app_i,
  input  logic             apply_i,
  input  logic             zero_i,
  input  logic [RES_W-1:0] code_i,
  output logic [RES_W-1:0] code_o
);
  logic [RES_W-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge clr_rst_ni) begin
    if (!clr_rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (zero_i) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (stage_i || stg_app_i) pend_q <= code_i;
      if (stg_app_i)            act_q  <= code_i;
      else if (apply_i)         act_q  <= pend_q;
    end
  end

  assign code_o = act_q;

  a_r2_stage_holds_out: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    (stage_i && !stg_app_i && !apply_i && !zero_i) |=> $stable(act_q));
  a_r3_apply_copies: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    (apply_i && !stg_app_i && !zero_i) |=> act_q == $past(pend_q));
  a_r4_stg_app_both: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    (stg_app_i && !zero_i) |=> (act_q == $past(code_i)) && (pend_q == $past(code_i)));
  a_r9_zero_all: assert property (@(posedge clk_i) disable iff (!clr_rst_ni)
    zero_i |=> (act_q == '0) && (pend_q == '0));
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacc_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_ni,
  input  logic                    sclk_i,
  input  logic                    cs_n_i,
  input  logic                    sdi_i,
  output logic [NUM_CH*RES_W-1:0] code_o,
  output logic [NUM_CH-1:0]       pwr_dn_o,
  output logic [1:0]              ref_sel_o
);
  logic              clr_rst_n;
  logic [2:0]        pins_s;
  logic              frame_vld;
  logic [FRAME_W-1:0] frame_bits;
  frame_t            frame;
  logic [NUM_CH-1:0] stage, stg_app, apply, pwr_en;
  logic              pwr_val, ref_en, zero, sw_rst;
  ref_e              ref_val, ref_q;
  logic [RES_W-1:0]  dec_code;
  logic [NUM_CH-1:0] pwr_q;

  assign clr_rst_n = rst_ni & clr_ni;

  dacc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_n_i, sdi_i}),
    .q_o    (pins_s)
  );

  dacc_spi_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_rst_ni  (clr_rst_n),
    .sclk_i      (pins_s[2]),
    .cs_n_i      (pins_s[1]),
    .sdi_i       (pins_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame_bits)
  );

  assign frame = frame_t'(frame_bits);

  dacc_decode #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dec (
    .frame_vld_i (frame_vld),
    .frame_i     (frame),
    .stage_o     (stage),
    .stg_app_o   (stg_app),
    .apply_o     (apply),
    .pwr_en_o    (pwr_en),
    .pwr_val_o   (pwr_val),
    .ref_en_o    (ref_en),
    .ref_val_o   (ref_val),
    .zero_o      (zero),
    .sw_rst_o    (sw_rst),
    .code_o      (dec_code)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dacc_chan #(.RES_W(RES_W)) u_chan (
      .clk_i      (clk_i),
      .clr_rst_ni (clr_rst_n),
      .stage_i    (stage[ch]),
      .stg_app_i  (stg_app[ch]),
      .apply_i    (apply[ch]),
      .zero_i     (zero),
      .code_i     (dec_code),
      .code_o     (code_o[ch*RES_W +: RES_W])
    );
  end

  // power and reference state survive the clear pin, only power-on and software reset touch them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= '0;
      ref_q <= REF_EXT;
    end else if (sw_rst) begin
      pwr_q <= '0;
      ref_q <= REF_EXT;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (pwr_en[ch]) pwr_q[ch] <= pwr_val;
      if (ref_en) ref_q <= ref_val;
    end
  end

  assign pwr_dn_o  = pwr_q;
  assign ref_sel_o = ref_q;

  a_r11_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (code_o == '0));
  a_r7_pwr_keeps_code: assert property (@(posedge clk_i) disable iff (!clr_rst_n)
    (|pwr_en) |=> $stable(code_o));
  a_r8_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_en && !sw_rst) |=> $stable(ref_sel_o));
  a_r10_sw_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> (pwr_dn_o == '0) && (ref_sel_o == REF_EXT));
endmodule

// File: tb/sim_dual_dac_ctrl.sv
module sim_dual_dac_ctrl;
  localparam int RES_W = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_ni = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [23:0] code;
  logic [1:0]  pwr_dn;
  logic [1:0]  ref_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dual_dac_ctrl u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .clr_ni    (clr_ni),
    .sclk_i    (sclk),
    .cs_n_i    (cs_n),
    .sdi_i     (sdi),
    .code_o    (code),
    .pwr_dn_o  (pwr_dn),
    .ref_sel_o (ref_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic [3:0] cmd, input logic [3:0] sel,
                                      input logic [11:0] c);
    return {cmd, sel, c, 4'h0};
  endfunction

  task automatic spi_begin();
    cs_n = 1'b0;
    wclk(4);
  endtask

  task automatic spi_bit(input logic b);
    sdi = b;
    wclk(3);
    sclk = 1'b1;
    wclk(4);
    sclk = 1'b0;
    wclk(3);
  endtask

  task automatic spi_end();
    wclk(3);
    cs_n = 1'b1;
    wclk(12);
  endtask

  task automatic send(input logic [23:0] f, input int nbits);
    spi_begin();
    for (int i = 0; i < nbits; i++) spi_bit(i < 24 ? f[23-i] : 1'b0);
    spi_end();
  endtask

  task automatic t_reset();
    chk("R1 codes", 32'(code), 0);
    chk("R1 pwr", 32'(pwr_dn), 0);
    chk("R1 ref", 32'(ref_sel), 0);
  endtask

  task automatic t_stage_apply();
    send(mk(4'h0, 4'h0, 12'hABC), 24);
    chk("R2 stage no output", 32'(code), 0);
    send(mk(4'h1, 4'h0, 12'h000), 24);
    chk("R3 apply ch0", 32'(code[11:0]), 32'hABC);
    chk("R3 ch1 untouched", 32'(code[23:12]), 0);
  endtask

  task automatic t_stage_and_apply();
    send(mk(4'h2, 4'h1, 12'h123), 24);
    chk("R4 ch1 direct", 32'(code[23:12]), 32'h123);
    chk("R4 ch0 kept", 32'(code[11:0]), 32'hABC);
  endtask

  task automatic t_select();
    send(mk(4'h2, 4'hF, 12'h5A5), 24);
    chk("R5 all channels", 32'(code), 32'h5A55A5);
    send(mk(4'h2, 4'h3, 12'hFFF), 24);
    chk("R5 bad select out", 32'(code), 32'h5A55A5);
    send(mk(4'h1, 4'hF, 12'h000), 24);
    chk("R5 bad select staging", 32'(code), 32'h5A55A5);
  endtask

  task automatic t_justify();
    send({4'h2, 4'h0, 16'h7FFF}, 24);
    chk("R6 left justified", 32'(code[11:0]), 32'h7FF);
  endtask

  task automatic t_power();
    send({4'h4, 4'h1, 16'h0001}, 24);
    chk("R7 ch1 down", 32'(pwr_dn), 32'h2);
    chk("R7 codes kept", 32'(code), 32'h5A57FF);
    send(mk(4'h0, 4'h1, 12'h321), 24);
    send(mk(4'h1, 4'h1, 12'h000), 24);
    chk("R7 update while down", 32'(code[23:12]), 32'h321);
    chk("R7 still down", 32'(pwr_dn), 32'h2);
    send({4'h4, 4'hF, 16'h0000}, 24);
    chk("R7 all up", 32'(pwr_dn), 0);
    chk("R7 codes after up", 32'(code), 32'h3217FF);
  endtask

  task automatic t_ref();
    send({4'h7, 4'h9, 16'h0002}, 24);
    chk("R8 ref 2.5", 32'(ref_sel), 32'h2);
    send({4'h7, 4'h0, 16'h0003}, 24);
    chk("R8 ref 4.096", 32'(ref_sel), 32'h3);
  endtask

  task automatic t_sw_clear();
    send({4'h4, 4'h0, 16'h0001}, 24);
    send(mk(4'h5, 4'h0, 12'h000), 24);
    chk("R9 codes zero", 32'(code), 0);
    chk("R9 pwr kept", 32'(pwr_dn), 32'h1);
    chk("R9 ref kept", 32'(ref_sel), 32'h3);
    send(mk(4'h1, 4'hF, 12'h000), 24);
    chk("R9 staging zero", 32'(code), 0);
  endtask

  task automatic t_sw_reset();
    send(mk(4'h2, 4'hF, 12'h0F0), 24);
    send(mk(4'h6, 4'h0, 12'h000), 24);
    chk("R10 codes zero", 32'(code), 0);
    chk("R10 pwr up", 32'(pwr_dn), 0);
    chk("R10 ref ext", 32'(ref_sel), 0);
  endtask

  task automatic t_length();
    send(mk(4'h2, 4'hF, 12'h246), 24);
    send(mk(4'h2, 4'h0, 12'h111), 23);
    chk("R13 short frame", 32'(code), 32'h246246);
    send(mk(4'h2, 4'h0, 12'h111), 25);
    chk("R13 long frame", 32'(code), 32'h246246);
    send(mk(4'h9, 4'hF, 12'h999), 24);
    send(mk(4'h3, 4'hF, 12'h999), 24);
    chk("R13 unknown cmd", 32'(code), 32'h246246);
    chk("R13 unknown cmd ctrl", 32'({pwr_dn, ref_sel}), 0);
    send(mk(4'h1, 4'hF, 12'h000), 24);
    chk("R13 staging intact", 32'(code), 32'h246246);
  endtask

  task automatic t_clear_pin();
    logic [23:0] f;
    send({4'h4, 4'h0, 16'h0001}, 24);
    send({4'h7, 4'h0, 16'h0001}, 24);
    f = mk(4'h2, 4'hF, 12'hEEE);
    spi_begin();
    for (int i = 0; i < 10; i++) spi_bit(f[23-i]);
    clr_ni = 1'b0;
    #1;
    chk("R11 async zero", 32'(code), 0);
    chk("R11 pwr kept", 32'(pwr_dn), 32'h1);
    chk("R11 ref kept", 32'(ref_sel), 32'h1);
    wclk(5);
    clr_ni = 1'b1;
    for (int i = 10; i < 24; i++) spi_bit(f[23-i]);
    spi_end();
    chk("R12 aborted frame", 32'(code), 0);
    send(mk(4'h1, 4'hF, 12'h000), 24);
    chk("R11 staging zero", 32'(code), 0);
    send(mk(4'h2, 4'h1, 12'h777), 24);
    chk("R12 next frame ok", 32'(code), 32'h777000);
  endtask

  initial begin
    wclk(3);
    rst_ni = 1'b1;
    wclk(3);
    t_reset();
    t_stage_apply();
    t_stage_and_apply();
    t_select();
    t_justify();
    t_power();
    t_ref();
    t_sw_clear();
    t_sw_reset();
    t_length();
    t_clear_pin();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule